// File: doc/BRIEF.md
# Event-Selectable Performance Counter Unit

This block gives one processor core a set of four 64-bit event counters. Counter 0 is set aside for counting clock cycles. Counters 1 to 3 are general purpose, and each one follows the event line picked by a 6-bit select code. The event lines come from the rest of the core on a plain input bus.

Two select codes never count. One code freezes a counter and another holds it at zero, so software starts, stops and clears a counter by rewriting its select field. Software can also preload any counter with the two's complement of a sample period. The counter then wraps after exactly that many events. If that counter's interrupt enable is set, the wrap sets a shared sticky flag, and the flag drives the interrupt output until software writes it back to zero.

An ownership register lends single counters to user-level code. Any other user-level access is refused: it reads as zero, has no effect and pulses a fault output.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset all counters, interrupt enables, the sticky flag and the ownership register are zero. The select field of counter 0 is 0 and the select fields of counters 1 to 3 are 48. `irq_o` and `fault_o` are low.
- R2: Select code 0 adds one on every clock edge. A select code c from 1 to 47 adds one on each edge where `evt_i[c]` is high. Examples: code 3 counts executed instructions, 15 counts stall cycles and 17 counts taken branches.
- R3: Select code 48 freezes the counter at its value.
- R4: Select code 49 forces the counter to zero on every edge.
- R5: Select codes 50 to 63 count nothing, whatever the event bus carries.
- R6: Register map. Address 0 is control: enable of counter i at bit i, sticky flag at bit 7, select of counter i at bits [8+6i+5 : 8+6i]. Address 1 is ownership: counter i at bits [2i+1 : 2i]. Address 2+i is counter i. Addresses 6 and 7 read as zero and ignore writes.
- R7: A bus write to a counter loads `wdata_i` at that edge. It wins over a counting event or a clear code in the same cycle.
- R8: A counter that steps from all ones to zero while its enable bit is set sets the sticky flag at that edge. `irq_o` follows the flag. A counter preloaded with -N therefore raises `irq_o` on the Nth event.
- R9: With its enable bit clear, a counter still wraps to zero but leaves the sticky flag and `irq_o` unchanged.
- R10: The sticky flag stays set until a control write with bit 7 at zero. `irq_o` is low the cycle after that write. A wrap in the same cycle as that write keeps the flag set.
- R11: A user-level access (`user_i` high) is granted only for a counter whose ownership field is 1. Any other user-level access reads zero, is not written, and raises `fault_o` for exactly one cycle.
- R12: Read data is presented on `rdata_o` one cycle after `rd_en_i`. It holds until the next read. A counter read returns the value the counter had before that edge's update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 47 | Event lines for select codes 1 to 47 (bit c for code c) |
| wr_en_i | input | 1 | One-cycle register write strobe |
| rd_en_i | input | 1 | One-cycle register read strobe |
| user_i | input | 1 | Access comes from user level |
| addr_i | input | 3 | Register address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, valid one cycle after the read strobe |
| irq_o | output | 1 | Shared overflow interrupt (sticky flag) |
| fault_o | output | 1 | One-cycle pulse on a refused user-level access |

## Verification
Register and counter state changes on the edge that samples a write strobe. A wrap sets `irq_o` on the same edge as the counted event. `rdata_o` and `fault_o` appear one edge after a read strobe. The bench drives inputs on the falling edge and reads results on the following falling edge, after exactly one rising edge. Each counting window is bracketed by two control writes, so the expected count is the idle cycles plus one: the closing write's own edge still counts with the old code. The overflow test steps the event line one edge at a time, so `irq_o` is seen low before the Nth event and high right after it.

// File: rtl/perf_counter_unit.sv
module perf_counter_unit #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 64,
  parameter int DATA_W  = 64,
  parameter int SEL_W   = 6,
  parameter int NUM_EVT = 48,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EVT-1:1] evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              user_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fault_o
);

  localparam int EXT        = 1 << SEL_W;
  localparam int CODE_STOP  = NUM_EVT;
  localparam int CODE_CLR   = NUM_EVT + 1;
  localparam int STICKY_BIT = 7;
  localparam int SEL_LSB    = 8;
  localparam int ADDR_CTL   = 0;
  localparam int ADDR_OWN   = 1;
  localparam int ADDR_CTR0  = 2;

  logic [SEL_W-1:0]     sel_q [NUM_CTR];
  logic [CTR_W-1:0]     cnt_q [NUM_CTR];
  logic [NUM_CTR-1:0]   ie_q;
  logic                 sticky_q;
  logic [2*NUM_CTR-1:0] own_q;

  logic [EXT-1:0]     evt_ext;
  logic [NUM_CTR-1:0] ctr_sel, user_ok, wr_hit, tick, wrap;
  logic               ctl_ok, own_ok, denied, ovf;
  logic [DATA_W-1:0]  ctl_img, rd_mux;

  assign evt_ext = {{(EXT-NUM_EVT){1'b0}}, evt_i, 1'b1};
  assign ctl_ok  = (addr_i == ADDR_W'(ADDR_CTL)) && !user_i;
  assign own_ok  = (addr_i == ADDR_W'(ADDR_OWN)) && !user_i;
  assign denied  = (rd_en_i || wr_en_i) && user_i && !(|(ctr_sel & user_ok));
  assign ovf     = |(wrap & ie_q);
  assign irq_o   = sticky_q;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign ctr_sel[i] = (addr_i == ADDR_W'(ADDR_CTR0 + i));
    assign user_ok[i] = (own_q[2*i +: 2] == 2'd1);
    assign wr_hit[i]  = wr_en_i && ctr_sel[i] && (!user_i || user_ok[i]);
    assign tick[i]    = evt_ext[sel_q[i]];
    assign wrap[i]    = !wr_hit[i] && (sel_q[i] != SEL_W'(CODE_CLR)) && tick[i] && (&cnt_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel_q[i] <= (i == 0) ? '0 : SEL_W'(CODE_STOP);
      else if (wr_en_i && ctl_ok)
        sel_q[i] <= wdata_i[SEL_LSB + SEL_W*i +: SEL_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt_q[i] <= '0;
      else if (wr_hit[i])
        cnt_q[i] <= wdata_i[CTR_W-1:0];
      else if (sel_q[i] == SEL_W'(CODE_CLR))
        cnt_q[i] <= '0;
      else if (tick[i])
        cnt_q[i] <= cnt_q[i] + 1'b1;
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[i] == SEL_W'(CODE_STOP) && !wr_hit[i]) |=> $stable(cnt_q[i]));
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[i] == SEL_W'(CODE_CLR) && !wr_hit[i]) |=> (cnt_q[i] == '0));
    p_idle_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[i] > SEL_W'(CODE_CLR) && !wr_hit[i]) |=> $stable(cnt_q[i]));
    p_preload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[i] |=> (cnt_q[i] == $past(wdata_i[CTR_W-1:0])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q     <= '0;
      sticky_q <= 1'b0;
      own_q    <= '0;
    end else begin
      if (wr_en_i && ctl_ok) begin
        ie_q     <= wdata_i[NUM_CTR-1:0];
        sticky_q <= wdata_i[STICKY_BIT] | ovf;
      end else begin
        sticky_q <= sticky_q | ovf;
      end
      if (wr_en_i && own_ok)
        own_q <= wdata_i[2*NUM_CTR-1:0];
    end
  end

  always_comb begin
    ctl_img = '0;
    ctl_img[NUM_CTR-1:0] = ie_q;
    ctl_img[STICKY_BIT]  = sticky_q;
    for (int i = 0; i < NUM_CTR; i++)
      ctl_img[SEL_LSB + SEL_W*i +: SEL_W] = sel_q[i];
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(ADDR_CTL)) rd_mux = ctl_img;
    if (addr_i == ADDR_W'(ADDR_OWN)) rd_mux = DATA_W'(own_q);
    for (int i = 0; i < NUM_CTR; i++)
      if (ctr_sel[i]) rd_mux = DATA_W'(cnt_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
      fault_o <= 1'b0;
    end else begin
      fault_o <= denied;
      if (rd_en_i)
        rdata_o <= denied ? '0 : rd_mux;
    end
  end

  p_irq_on_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> irq_o);
  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(wr_en_i && ctl_ok)) |=> irq_o);
  p_fault_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && denied) |=> (fault_o && rdata_o == '0));
  p_fault_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_i || wr_en_i) |=> !fault_o);

endmodule

// File: tb/perf_counter_unit_test.sv
module perf_counter_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:1] evt = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, user = 1'b0;
  logic [2:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        irq, fault;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] v, v2;
  logic        f;

  always #5 clk = ~clk;

  perf_counter_unit uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .user_i(user), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .fault_o(fault));

  // {code, event(0 none, FF all, else bit), preload, idle cycles, expected}
  localparam logic [39:0] VEC [11] = '{
    {8'd0,  8'd0,   8'd0,  8'd5, 8'd6},
    {8'd3,  8'd3,   8'd0,  8'd4, 8'd5},
    {8'd3,  8'd17,  8'd0,  8'd4, 8'd0},
    {8'd17, 8'd17,  8'd10, 8'd2, 8'd13},
    {8'd15, 8'd15,  8'd0,  8'd7, 8'd8},
    {8'd47, 8'd47,  8'd1,  8'd0, 8'd2},
    {8'd1,  8'hFF,  8'd0,  8'd2, 8'd3},
    {8'd48, 8'd3,   8'd9,  8'd4, 8'd9},
    {8'd49, 8'd3,   8'd9,  8'd3, 8'd0},
    {8'd50, 8'hFF,  8'd7,  8'd3, 8'd7},
    {8'd63, 8'hFF,  8'd7,  8'd3, 8'd7}
  };

  function automatic logic [63:0] ctlv(int s1, logic [3:0] ie, bit st);
    logic [63:0] r = '0;
    r[3:0]   = ie;
    r[7]     = st;
    r[13:8]  = 6'd0;
    r[19:14] = 6'(s1);
    r[25:20] = 6'd48;
    r[31:26] = 6'd48;
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(logic [2:0] a, logic [63:0] d, logic u);
    addr = a; wdata = d; user = u; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; user = 1'b0;
  endtask

  task automatic brd(logic [2:0] a, logic u, output logic [63:0] d, output logic fl);
    addr = a; user = u; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; user = 1'b0;
    d = rdata; fl = fault;
  endtask

  task automatic set_evt(int e);
    evt = '0;
    if (e == 8'hFF) evt = '1;
    else if (e != 0) evt[e] = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 irq after reset", 64'(irq), 64'd0);
    chk("R1 fault after reset", 64'(fault), 64'd0);
    brd(3'd0, 1'b0, v, f);
    chk("R1 control reset image", v, ctlv(48, 4'b0000, 1'b0));
    brd(3'd1, 1'b0, v, f);
    chk("R1 ownership reset", v, 64'd0);
    brd(3'd4, 1'b0, v, f);
    chk("R1 counter2 reset", v, 64'd0);
    brd(3'd2, 1'b0, v, f);
    brd(3'd2, 1'b0, v2, f);
    chk("R2 counter0 cycle step", v2 - v, 64'd1);

    for (int n = 0; n < 11; n++) begin
      bwr(3'd0, ctlv(48, 4'b0000, 1'b0), 1'b0);
      bwr(3'd3, 64'(VEC[n][23:16]), 1'b0);
      set_evt(int'(VEC[n][31:24]));
      bwr(3'd0, ctlv(int'(VEC[n][39:32]), 4'b0000, 1'b0), 1'b0);
      repeat (int'(VEC[n][15:8])) @(negedge clk);
      bwr(3'd0, ctlv(48, 4'b0000, 1'b0), 1'b0);
      evt = '0;
      brd(3'd3, 1'b0, v, f);
      chk($sformatf("R2/R3/R4/R5 vector %0d code %0d", n, VEC[n][39:32]), v, 64'(VEC[n][7:0]));
    end

    // R7: write wins over counting and clear
    bwr(3'd0, ctlv(0, 4'b0000, 1'b0), 1'b0);
    bwr(3'd3, 64'd100, 1'b0);
    brd(3'd3, 1'b0, v, f);
    chk("R7 write over count", v, 64'd100);
    brd(3'd3, 1'b0, v, f);
    chk("R7 counting resumes", v, 64'd101);
    bwr(3'd0, ctlv(49, 4'b0000, 1'b0), 1'b0);
    bwr(3'd3, 64'd77, 1'b0);
    brd(3'd3, 1'b0, v, f);
    chk("R7 write over clear", v, 64'd77);

    // R12: read data holds
    @(negedge clk);
    chk("R12 rdata holds", rdata, 64'd77);
    brd(3'd7, 1'b0, v, f);
    chk("R6 unmapped reads zero", v, 64'd0);

    // R8: preload -3 wraps on third event
    bwr(3'd0, ctlv(3, 4'b0010, 1'b0), 1'b0);
    bwr(3'd3, -64'sd3, 1'b0);
    evt[3] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 no irq before Nth event", 64'(irq), 64'd0);
    @(negedge clk);
    evt = '0;
    chk("R8 irq on Nth event", 64'(irq), 64'd1);
    brd(3'd3, 1'b0, v, f);
    chk("R8 counter wrapped to zero", v, 64'd0);
    repeat (3) @(negedge clk);
    chk("R10 irq stays set", 64'(irq), 64'd1);
    brd(3'd0, 1'b0, v, f);
    chk("R6 sticky bit 7 visible", v, ctlv(3, 4'b0010, 1'b1));
    bwr(3'd0, ctlv(3, 4'b0010, 1'b0), 1'b0);
    chk("R10 irq cleared by write", 64'(irq), 64'd0);

    // R10: wrap in same cycle as clearing write
    bwr(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    evt[3] = 1'b1;
    bwr(3'd0, ctlv(3, 4'b0010, 1'b0), 1'b0);
    evt = '0;
    chk("R10 wrap beats clear", 64'(irq), 64'd1);
    bwr(3'd0, ctlv(3, 4'b0010, 1'b0), 1'b0);
    chk("R10 second clear", 64'(irq), 64'd0);

    // R9: wrap with enable off
    bwr(3'd0, ctlv(3, 4'b0000, 1'b0), 1'b0);
    bwr(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    evt[3] = 1'b1;
    @(negedge clk);
    evt = '0;
    chk("R9 no irq when disabled", 64'(irq), 64'd0);
    brd(3'd3, 1'b0, v, f);
    chk("R9 counter still wraps", v, 64'd0);

    // R11: user access
    bwr(3'd0, ctlv(48, 4'b0000, 1'b0), 1'b0);
    bwr(3'd3, 64'd321, 1'b0);
    bwr(3'd1, 64'h4, 1'b0);
    brd(3'd3, 1'b1, v, f);
    chk("R11 granted user read", v, 64'd321);
    chk("R11 granted no fault", 64'(f), 64'd0);
    brd(3'd4, 1'b1, v, f);
    chk("R11 refused read zero", v, 64'd0);
    chk("R11 refused read fault", 64'(f), 64'd1);
    @(negedge clk);
    chk("R11 fault one cycle", 64'(fault), 64'd0);
    bwr(3'd3, 64'd555, 1'b1);
    brd(3'd3, 1'b0, v, f);
    chk("R11 granted user write", v, 64'd555);
    bwr(3'd4, 64'd999, 1'b1);
    chk("R11 refused write fault", 64'(fault), 64'd1);
    brd(3'd4, 1'b0, v, f);
    chk("R11 refused write ignored", v, 64'd0);
    bwr(3'd0, ctlv(3, 4'b1111, 1'b1), 1'b1);
    brd(3'd0, 1'b0, v, f);
    chk("R11 user control write ignored", v, ctlv(48, 4'b0000, 1'b0));
    bwr(3'd1, 64'h8, 1'b0);
    brd(3'd3, 1'b1, v, f);
    chk("R11 ownership 2 is kernel", v, 64'd0);
    chk("R11 ownership 2 faults", 64'(f), 64'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule